// File: doc/BRIEF.md
# Debug Halt Sequencer

This block moves a processor core into and out of a halted debug state. A breakpoint request does not stop the core at once: it is parked as pending until an instruction retires at a point where no write cycle is still outstanding. At that retirement the core freezes and the block records the address of that retiring instruction. Because a write left in flight lets later instructions run on, the recorded address may belong to an instruction up to two places after the one that raised the breakpoint. A double bus fault taken straight out of reset also halts the core, and in that case a fixed marker value is recorded instead of an address.

While frozen, the shared debug pins are handed to the serial debug port. A resume command or a call-user-code command ends the halt. The return address in force when the command arrives is taken, including any value written to it while halted. Freeze drops first, and the pins go back to pipeline status. One cycle later a single-cycle flush and refetch pulse is issued toward the return address.

Top module: `dbg_halt_ctrl`

## Requirements
- R1: After reset the state is RUN (`dbg_state` = 4'b0001), `freeze`, `pins_serial`, `flush` and `refetch` are 0, and `halt_pc` and `refetch_addr` are 0.
- R2: A `bkpt_req` sampled in RUN moves the block to PENDING (`dbg_state` = 4'b0010) at that clock edge, with `freeze` still 0.
- R3: In PENDING, an `insn_retire` with `wr_pend` = 0 moves the block to DEBUG (`dbg_state` = 4'b0100) at that edge: `freeze` becomes 1 and `halt_pc` takes that cycle's `insn_addr`.
- R4: In PENDING, an `insn_retire` with `wr_pend` = 1 leaves the block in PENDING with `halt_pc` unchanged, so the address recorded later is that of a following instruction.
- R5: A `dfault_rst` sampled in RUN moves the block to DEBUG at that edge with `halt_pc` = 32'h00000001, taking priority over a `bkpt_req` in the same cycle.
- R6: `pins_serial` is 1 exactly when `freeze` is 1, in every cycle.
- R7: In DEBUG, `cmd_resume` or `cmd_call` moves the block to EXITING (`dbg_state` = 4'b1000) at that edge: `freeze` and `pins_serial` become 0 and `refetch_addr` takes that cycle's `ret_addr`.
- R8: `flush` and `refetch` are both 1 for exactly the one cycle after EXITING, which is one cycle after `freeze` falls, and the state is then RUN.
- R9: Changes to `ret_addr` made while in DEBUG are honoured. Only the value present with the exit command is used.
- R10: `cmd_resume` and `cmd_call` have no effect outside DEBUG.
- R11: `bkpt_req` has no effect in PENDING, DEBUG or EXITING.
- R12: The state is one-hot with RUN = bit 0, PENDING = bit 1, DEBUG = bit 2 and EXITING = bit 3, exactly one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bkpt_req | input | 1 | Breakpoint request |
| insn_retire | input | 1 | Instruction-boundary strobe |
| insn_addr | input | AW | Address of the first word of the retiring instruction |
| wr_pend | input | 1 | A write bus cycle is still outstanding |
| dfault_rst | input | 1 | Double bus fault immediately after reset |
| cmd_resume | input | 1 | Decoded resume command |
| cmd_call | input | 1 | Decoded call-user-code command |
| ret_addr | input | AW | Current return-address register |
| freeze | output | 1 | Core halted in debug |
| pins_serial | output | 1 | Shared pins serve the serial debug port (1) or pipeline status (0) |
| flush | output | 1 | Pipeline flush pulse |
| refetch | output | 1 | Refetch request pulse |
| refetch_addr | output | AW | Refetch target address |
| halt_pc | output | AW | Recorded current-instruction address |
| dbg_state | output | 4 | One-hot sequencer state |

## Verification
Every decision is registered once. The effects of an entry, an exit, a breakpoint or a command are therefore visible one clock after the edge that samples the stimulus, and the flush and refetch pulse follows one clock later still. The bench drives inputs on the falling edge and checks on the falling edge after each rising edge, so each check lands in the first cycle where the result is due. It also checks the cycle after that to confirm that the pulse has ended. A sweep over the number of retirements with an outstanding write, the exit command type, and several return-address values gives the expected `halt_pc` and `refetch_addr` by arithmetic on the driven addresses.

// File: rtl/dbg_halt_pkg.sv
package dbg_halt_pkg;
  typedef enum logic [3:0] {
    ST_RUN   = 4'b0001,
    ST_PEND  = 4'b0010,
    ST_DEBUG = 4'b0100,
    ST_EXIT  = 4'b1000
  } dbg_state_e;

  localparam int STATE_W = 4;
endpackage

// File: rtl/dbg_seq_fsm.sv
module dbg_seq_fsm
  import dbg_halt_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       bkpt_req,
  input  logic       insn_retire,
  input  logic       wr_pend,
  input  logic       dfault_rst,
  input  logic       cmd_resume,
  input  logic       cmd_call,
  output dbg_state_e state,
  output logic       cap_insn,
  output logic       cap_fault,
  output logic       take_ret,
  output logic       freeze_q,
  output logic       serial_q,
  output logic       flush_q,
  output logic       refetch_q
);
  dbg_state_e state_n;
  logic       any_exit_cmd;

  assign any_exit_cmd = cmd_resume | cmd_call;

  // boundary where a pending breakpoint may be honoured
  assign cap_insn  = (state == ST_PEND) && insn_retire && !wr_pend;
  assign cap_fault = (state == ST_RUN) && dfault_rst;
  assign take_ret  = (state == ST_DEBUG) && any_exit_cmd;

  always_comb begin
    state_n = state;
    case (state)
      ST_RUN: begin
        if (dfault_rst)    state_n = ST_DEBUG;
        else if (bkpt_req) state_n = ST_PEND;
      end
      ST_PEND: begin
        if (cap_insn) state_n = ST_DEBUG;
      end
      ST_DEBUG: begin
        if (any_exit_cmd) state_n = ST_EXIT;
      end
      ST_EXIT: state_n = ST_RUN;
      default: state_n = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_RUN;
      freeze_q  <= 1'b0;
      serial_q  <= 1'b0;
      flush_q   <= 1'b0;
      refetch_q <= 1'b0;
    end else begin
      state     <= state_n;
      freeze_q  <= (state_n == ST_DEBUG);
      serial_q  <= (state_n == ST_DEBUG);
      flush_q   <= (state == ST_EXIT);
      refetch_q <= (state == ST_EXIT);
    end
  end
endmodule

// File: rtl/dbg_addr_capture.sv
module dbg_addr_capture #(
  parameter int            AW        = 32,
  parameter logic [AW-1:0] FAULT_TAG = {{(AW-1){1'b0}}, 1'b1}
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cap_insn,
  input  logic          cap_fault,
  input  logic          take_ret,
  input  logic [AW-1:0] insn_addr,
  input  logic [AW-1:0] ret_addr,
  output logic [AW-1:0] halt_pc,
  output logic [AW-1:0] refetch_addr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      halt_pc      <= '0;
      refetch_addr <= '0;
    end else begin
      if (cap_fault)     halt_pc <= FAULT_TAG;
      else if (cap_insn) halt_pc <= insn_addr;
      if (take_ret)      refetch_addr <= ret_addr;
    end
  end
endmodule

// File: rtl/dbg_halt_ctrl.sv
module dbg_halt_ctrl
  import dbg_halt_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bkpt_req,
  input  logic          insn_retire,
  input  logic [AW-1:0] insn_addr,
  input  logic          wr_pend,
  input  logic          dfault_rst,
  input  logic          cmd_resume,
  input  logic          cmd_call,
  input  logic [AW-1:0] ret_addr,
  output logic          freeze,
  output logic          pins_serial,
  output logic          flush,
  output logic          refetch,
  output logic [AW-1:0] refetch_addr,
  output logic [AW-1:0] halt_pc,
  output logic [3:0]    dbg_state
);
  localparam logic [AW-1:0] FAULT_TAG = {{(AW-1){1'b0}}, 1'b1};

  dbg_state_e state;
  logic       cap_insn, cap_fault, take_ret;

  dbg_seq_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .bkpt_req   (bkpt_req),
    .insn_retire(insn_retire),
    .wr_pend    (wr_pend),
    .dfault_rst (dfault_rst),
    .cmd_resume (cmd_resume),
    .cmd_call   (cmd_call),
    .state      (state),
    .cap_insn   (cap_insn),
    .cap_fault  (cap_fault),
    .take_ret   (take_ret),
    .freeze_q   (freeze),
    .serial_q   (pins_serial),
    .flush_q    (flush),
    .refetch_q  (refetch)
  );

  dbg_addr_capture #(.AW(AW), .FAULT_TAG(FAULT_TAG)) u_cap (
    .clk         (clk),
    .rst         (rst),
    .cap_insn    (cap_insn),
    .cap_fault   (cap_fault),
    .take_ret    (take_ret),
    .insn_addr   (insn_addr),
    .ret_addr    (ret_addr),
    .halt_pc     (halt_pc),
    .refetch_addr(refetch_addr)
  );

  assign dbg_state = state;
endmodule

// File: rtl/dbg_halt_ctrl_chk.sv
module dbg_halt_ctrl_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          bkpt_req,
  input logic          insn_retire,
  input logic [AW-1:0] insn_addr,
  input logic          wr_pend,
  input logic          dfault_rst,
  input logic          cmd_resume,
  input logic          cmd_call,
  input logic [AW-1:0] ret_addr,
  input logic          freeze,
  input logic          pins_serial,
  input logic          flush,
  input logic          refetch,
  input logic [AW-1:0] refetch_addr,
  input logic [AW-1:0] halt_pc,
  input logic [3:0]    dbg_state
);
  a_r12_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot(dbg_state));

  a_r6_pins_follow_freeze: assert property (@(posedge clk) disable iff (rst)
    pins_serial == freeze);

  a_r2_pending: assert property (@(posedge clk) disable iff (rst)
    dbg_state[0] && bkpt_req && !dfault_rst |=> dbg_state[1] && !freeze);

  a_r3_entry: assert property (@(posedge clk) disable iff (rst)
    dbg_state[1] && insn_retire && !wr_pend |=> freeze && halt_pc == $past(insn_addr));

  a_r4_hold_on_write: assert property (@(posedge clk) disable iff (rst)
    dbg_state[1] && insn_retire && wr_pend |=> dbg_state[1] && $stable(halt_pc));

  a_r5_fault_tag: assert property (@(posedge clk) disable iff (rst)
    dbg_state[0] && dfault_rst |=> freeze && halt_pc == {{(AW-1){1'b0}}, 1'b1});

  a_r7_exit: assert property (@(posedge clk) disable iff (rst)
    dbg_state[2] && (cmd_resume || cmd_call) |=> !freeze && refetch_addr == $past(ret_addr));

  a_r8_refetch_after_fall: assert property (@(posedge clk) disable iff (rst)
    $fell(freeze) |=> refetch && flush);

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
    refetch |=> !refetch);

  a_r10_cmd_ignored: assert property (@(posedge clk) disable iff (rst)
    dbg_state[0] && !dfault_rst && !bkpt_req |=> dbg_state[0] && !freeze);

  a_r11_bkpt_ignored: assert property (@(posedge clk) disable iff (rst)
    dbg_state[2] && !cmd_resume && !cmd_call |=> dbg_state[2] && $stable(halt_pc));
endmodule

bind dbg_halt_ctrl dbg_halt_ctrl_chk #(.AW(AW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .bkpt_req    (bkpt_req),
  .insn_retire (insn_retire),
  .insn_addr   (insn_addr),
  .wr_pend     (wr_pend),
  .dfault_rst  (dfault_rst),
  .cmd_resume  (cmd_resume),
  .cmd_call    (cmd_call),
  .ret_addr    (ret_addr),
  .freeze      (freeze),
  .pins_serial (pins_serial),
  .flush       (flush),
  .refetch     (refetch),
  .refetch_addr(refetch_addr),
  .halt_pc     (halt_pc),
  .dbg_state   (dbg_state)
);

// File: tb/tb_dbg_halt_ctrl.sv
`timescale 1ns/1ps
module tb_dbg_halt_ctrl;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bkpt_req = 1'b0, insn_retire = 1'b0, wr_pend = 1'b0;
  logic          dfault_rst = 1'b0, cmd_resume = 1'b0, cmd_call = 1'b0;
  logic [AW-1:0] insn_addr = '0, ret_addr = '0;
  logic          freeze, pins_serial, flush, refetch;
  logic [AW-1:0] refetch_addr, halt_pc;
  logic [3:0]    dbg_state;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  dbg_halt_ctrl #(.AW(AW)) dut (
    .clk(clk), .rst(rst), .bkpt_req(bkpt_req), .insn_retire(insn_retire),
    .insn_addr(insn_addr), .wr_pend(wr_pend), .dfault_rst(dfault_rst),
    .cmd_resume(cmd_resume), .cmd_call(cmd_call), .ret_addr(ret_addr),
    .freeze(freeze), .pins_serial(pins_serial), .flush(flush), .refetch(refetch),
    .refetch_addr(refetch_addr), .halt_pc(halt_pc), .dbg_state(dbg_state)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_pins(input string req);
    chk(req, {31'b0, pins_serial}, {31'b0, freeze});
  endtask

  task automatic chk_exit(input logic [AW-1:0] exp_addr);
    chk("R7 state EXITING", {28'b0, dbg_state}, 32'h8);
    chk("R7 freeze low", {31'b0, freeze}, 32'h0);
    chk("R6 pins after exit", {31'b0, pins_serial}, 32'h0);
    chk("R8 no refetch yet", {30'b0, flush, refetch}, 32'h0);
    chk("R9 refetch_addr", refetch_addr, exp_addr);
    tick();
    chk("R8 flush+refetch", {30'b0, flush, refetch}, 32'h3);
    chk("R8 state RUN", {28'b0, dbg_state}, 32'h1);
    tick();
    chk("R8 pulse ended", {30'b0, flush, refetch}, 32'h0);
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] base;
    logic [AW-1:0] pc_hold;
    repeat (3) tick();
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 state", {28'b0, dbg_state}, 32'h1);
    chk("R1 outputs", {28'b0, freeze, pins_serial, flush, refetch}, 32'h0);
    chk("R1 halt_pc", halt_pc, 32'h0);
    chk("R1 refetch_addr", refetch_addr, 32'h0);

    // R10 commands in RUN ignored
    cmd_resume = 1'b1; cmd_call = 1'b1;
    tick();
    cmd_resume = 1'b0; cmd_call = 1'b0;
    chk("R10 RUN state", {28'b0, dbg_state}, 32'h1);
    chk("R10 RUN outputs", {28'b0, freeze, pins_serial, flush, refetch}, 32'h0);

    // R5 double fault with simultaneous breakpoint
    dfault_rst = 1'b1; bkpt_req = 1'b1;
    tick();
    dfault_rst = 1'b0; bkpt_req = 1'b0;
    chk("R5 state DEBUG", {28'b0, dbg_state}, 32'h4);
    chk("R5 halt_pc tag", halt_pc, 32'h00000001);
    chk("R5 freeze", {31'b0, freeze}, 32'h1);
    chk_pins("R6 pins in fault halt");
    ret_addr = 32'h0000_4000;
    cmd_call = 1'b1;
    tick();
    cmd_call = 1'b0;
    chk_exit(32'h0000_4000);

    // sweep: outstanding-write retirements x exit kind x return address
    for (int n = 0; n < 3; n++) begin
      for (int kind = 0; kind < 2; kind++) begin
        for (int r = 0; r < 3; r++) begin
          base = 32'h0010_0000 + 32'(n * 32'h1000) + 32'(kind * 32'h100) + 32'(r * 32'h10);
          pc_hold = halt_pc;
          bkpt_req = 1'b1;
          tick();
          bkpt_req = 1'b0;
          chk("R2 PENDING", {28'b0, dbg_state}, 32'h2);
          chk("R2 no freeze", {31'b0, freeze}, 32'h0);
          // R10 command in PENDING ignored; R11 bkpt in PENDING ignored
          cmd_resume = 1'b1; bkpt_req = 1'b1;
          tick();
          cmd_resume = 1'b0; bkpt_req = 1'b0;
          chk("R10 PENDING kept", {28'b0, dbg_state}, 32'h2);
          for (int k = 0; k < n; k++) begin
            insn_retire = 1'b1; wr_pend = 1'b1; insn_addr = base + 32'(4 * k);
            tick();
            chk("R4 still PENDING", {28'b0, dbg_state}, 32'h2);
            chk("R4 halt_pc held", halt_pc, pc_hold);
          end
          insn_retire = 1'b1; wr_pend = 1'b0; insn_addr = base + 32'(4 * n);
          tick();
          insn_retire = 1'b0; insn_addr = '0;
          chk("R3 DEBUG", {28'b0, dbg_state}, 32'h4);
          chk("R3 freeze", {31'b0, freeze}, 32'h1);
          chk("R3 halt_pc", halt_pc, base + 32'(4 * n));
          chk_pins("R6 pins in debug");
          // R11 breakpoint in DEBUG ignored
          bkpt_req = 1'b1;
          tick();
          bkpt_req = 1'b0;
          chk("R11 DEBUG kept", {28'b0, dbg_state}, 32'h4);
          chk("R11 halt_pc kept", halt_pc, base + 32'(4 * n));
          // R9 return address rewritten during DEBUG
          ret_addr = 32'hDEAD_0000;
          tick();
          ret_addr = 32'h0200_0000 + base;
          if (kind == 0) cmd_resume = 1'b1; else cmd_call = 1'b1;
          tick();
          cmd_resume = 1'b0; cmd_call = 1'b0;
          ret_addr = 32'hFFFF_FFFF;
          chk_exit(32'h0200_0000 + base);
        end
      end
    end

    // R11 breakpoint during EXITING ignored; R10 command in EXITING ignored
    dfault_rst = 1'b1;
    tick();
    dfault_rst = 1'b0;
    ret_addr = 32'h0000_8000;
    cmd_resume = 1'b1;
    tick();
    cmd_resume = 1'b0;
    bkpt_req = 1'b1; cmd_call = 1'b1;
    tick();
    bkpt_req = 1'b0; cmd_call = 1'b0;
    chk("R11 EXITING bkpt ignored state", {28'b0, dbg_state}, 32'h1);
    chk("R10 EXITING cmd ignored addr", refetch_addr, 32'h0000_8000);
    chk("R8 pulse after EXITING", {30'b0, flush, refetch}, 32'h3);
    tick();
    chk("R12 back to RUN", {28'b0, dbg_state}, 32'h1);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule